// File: doc/BRIEF.md
# Receive Byte Queue with Fill Threshold

This block holds the bytes a serial bus engine receives until software reads them. The engine offers one byte per push. A register read removes the oldest byte, and the data is valid in the same cycle as the read. A level output always shows how many bytes are stored. Software programs a fill threshold. From that threshold and the level, the block keeps a "fill reached" flag that interrupt logic outside the block uses.

Two sticky error flags record misuse. The first records a byte that arrives while the queue is full. The second records a read that finds nothing to return. Each flag is cleared by its own strobe. Disabling or aborting the controller raises a flush strobe. The flush discards the contents and returns the level and all flags to zero.

Top module: `rx_byte_queue`

## Requirements
- R1: The queue holds up to DEPTH (default 16) bytes in arrival order. `level` always equals the number of stored bytes. An accepted read returns the oldest byte on `pop_data` in the same cycle, and `level` drops one cycle later.
- R2: A threshold write stores the written value unchanged when it is at most DEPTH-1. A larger value is stored as DEPTH-1. `thr_value` shows the stored value one cycle after the write. A stored value T means the flag trips once more than T bytes are held.
- R3: After any push attempt that leaves the level greater than the stored threshold, `rx_full` is 1 in the next cycle.
- R4: After an accepted read that leaves the level at or below the threshold, `rx_full` is 0 in the next cycle.
- R5: A threshold write re-evaluates `rx_full` against the new value. The flag becomes 1 if the level exceeds the new threshold and `enable` is 1. Otherwise it becomes 0.
- R6: A push into a full queue, with no accepted read in the same cycle, discards the byte. It leaves the level and the contents unchanged and sets `rx_over`.
- R7: A read while `receiving` is 1 and the queue is empty returns 0 and sets `rx_under`.
- R8: A read while `receiving` is 0 returns 0 and does not change the contents or the level. It sets `rx_under` only when `engine_idle` is 0.
- R9: `flush` empties the queue. Bytes held before the flush are never returned. One cycle later, `level`, `rx_full`, `rx_over` and `rx_under` are 0.
- R10: An accepted push and an accepted read in the same cycle leave the level unchanged and keep the byte order.
- R11: `clr_over` clears `rx_over` and `clr_under` clears `rx_under`, one cycle later. If a new error occurs in the same cycle as the clear, the flag stays set.
- R12: After reset, `level`, `thr_value`, `rx_full`, `rx_over` and `rx_under` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enabled; gates the threshold re-evaluation |
| receiving | input | 1 | Engine is in its receive phase, so reads may pop |
| engine_idle | input | 1 | Engine is idle |
| flush | input | 1 | Disable or abort strobe; empties the queue and clears the flags |
| push_valid | input | 1 | Engine offers a received byte |
| push_data | input | DATA_W | Received byte |
| pop_req | input | 1 | Register read of the data port |
| pop_data | output | DATA_W | Byte returned by the read, or 0 |
| thr_wr | input | 1 | Threshold register write strobe |
| thr_wdata | input | THR_W | Threshold value written |
| thr_value | output | THR_W | Stored (clamped) threshold |
| level | output | LVL_W | Number of stored bytes |
| rx_full | output | 1 | Level exceeds the threshold |
| rx_over | output | 1 | Sticky: byte discarded on a full queue |
| rx_under | output | 1 | Sticky: read found nothing to return |
| clr_over | input | 1 | Clears `rx_over` |
| clr_under | input | 1 | Clears `rx_under` |

## Verification
Three cases are hard to reach from the ports. The first is a push on an exactly full queue. The second is a threshold write with `enable` low while the queue holds data. The third is a read with `receiving` low, once with the engine busy and once with it idle. To reach them, the stimulus first fills the queue to its limit through single pushes, with one combined push and read along the way. It then toggles the engine state inputs between reads and drains the whole queue, so that the byte order is confirmed across the pointer wrap.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Limit a software-written threshold to the largest legal value.
  function automatic int unsigned clamp_thr(int unsigned raw, int unsigned top);
    return (raw > top) ? top : raw;
  endfunction

  // Occupancy after one cycle of accepted push/pop traffic.
  function automatic int unsigned next_level(int unsigned cur, logic push, logic pop);
    int unsigned n;
    n = cur;
    if (push && !pop) n = cur + 1;
    if (pop && !push) n = cur - 1;
    return n;
  endfunction

  // Pointer advance with wrap for any depth.
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push_ok,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_ok,
  output logic [DATA_W-1:0] head_data,
  output logic [LVL_W-1:0]  count
);
  import rxq_pkg::*;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= PTR_W'(wrap_inc(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= PTR_W'(wrap_inc(int'(rd_ptr), DEPTH));
      count <= LVL_W'(next_level(int'(count), push_ok, pop_ok));
    end
  end

  assign head_data = mem[rd_ptr];

  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && !pop_ok && !flush |=> count == $past(count) + 1'b1); // R1
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok && !push_ok && !flush |=> count == $past(count) - 1'b1); // R1
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int DEPTH = 16,
  parameter int THR_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             flush,
  input  logic             thr_wr,
  input  logic [THR_W-1:0] thr_wdata,
  input  logic             push_seen,
  input  logic             pop_ok,
  input  logic [LVL_W-1:0] level_nx,
  input  logic             ovf_ev,
  input  logic             unf_ev,
  input  logic             clr_over,
  input  logic             clr_under,
  output logic [THR_W-1:0] thr_q,
  output logic             rx_full,
  output logic             rx_over,
  output logic             rx_under
);
  import rxq_pkg::*;

  logic [THR_W-1:0] thr_new;
  logic             above_new, above_cur;

  assign thr_new   = THR_W'(clamp_thr(int'(thr_wdata), DEPTH - 1));
  assign above_new = int'(level_nx) > int'(thr_new);
  assign above_cur = int'(level_nx) > int'(thr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else if (thr_wr) thr_q <= thr_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rx_full <= 1'b0;
    else if (flush)                  rx_full <= 1'b0;
    else if (thr_wr)                 rx_full <= above_new && enable;
    else if (push_seen && above_cur) rx_full <= 1'b1;
    else if (pop_ok && !above_cur)   rx_full <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_over  <= 1'b0;
      rx_under <= 1'b0;
    end else if (flush) begin
      rx_over  <= 1'b0;
      rx_under <= 1'b0;
    end else begin
      if (ovf_ev)         rx_over <= 1'b1;
      else if (clr_over)  rx_over <= 1'b0;
      if (unf_ev)         rx_under <= 1'b1;
      else if (clr_under) rx_under <= 1'b0;
    end
  end

  AST_THR_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr && (int'(thr_wdata) > DEPTH - 1) |=> int'(thr_q) == DEPTH - 1); // R2
  AST_OVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev && !flush |=> rx_over); // R6
  AST_UNDER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    unf_ev && !flush |=> rx_under); // R7
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rx_full && !rx_over && !rx_under); // R9
  AST_THR_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr && !enable |=> !rx_full); // R5
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int THR_W  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              receiving,
  input  logic              engine_idle,
  input  logic              flush,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  input  logic              thr_wr,
  input  logic [THR_W-1:0]  thr_wdata,
  output logic [THR_W-1:0]  thr_value,
  output logic [LVL_W-1:0]  level,
  output logic              rx_full,
  output logic              rx_over,
  output logic              rx_under,
  input  logic              clr_over,
  input  logic              clr_under
);
  import rxq_pkg::*;

  // Named internal events, shared by the submodules and the assertions.
  logic              q_empty, q_full;
  logic              pop_ok, push_ok, ovf_ev, unf_ev;
  logic [LVL_W-1:0]  level_nx;
  logic [DATA_W-1:0] head_data;

  assign q_empty  = (level == '0);
  assign q_full   = (int'(level) == DEPTH);
  assign pop_ok   = pop_req && receiving && !q_empty;
  assign push_ok  = push_valid && (!q_full || pop_ok);
  assign ovf_ev   = push_valid && q_full && !pop_ok;
  assign unf_ev   = pop_req && (receiving ? q_empty : !engine_idle);
  assign level_nx = LVL_W'(next_level(int'(level), push_ok, pop_ok));
  assign pop_data = pop_ok ? head_data : '0;

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push_ok   (push_ok),
    .push_data (push_data),
    .pop_ok    (pop_ok),
    .head_data (head_data),
    .count     (level)
  );

  rxq_flags #(.DEPTH(DEPTH), .THR_W(THR_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .flush     (flush),
    .thr_wr    (thr_wr),
    .thr_wdata (thr_wdata),
    .push_seen (push_valid),
    .pop_ok    (pop_ok),
    .level_nx  (level_nx),
    .ovf_ev    (ovf_ev),
    .unf_ev    (unf_ev),
    .clr_over  (clr_over),
    .clr_under (clr_under),
    .thr_q     (thr_value),
    .rx_full   (rx_full),
    .rx_over   (rx_over),
    .rx_under  (rx_under)
  );

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH); // R1
  AST_PAIR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && pop_ok && !flush |=> $stable(level)); // R10
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev && !flush |=> int'(level) == DEPTH); // R6
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && !receiving && !flush && !push_valid |=> $stable(level)); // R8
  AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !flush && !thr_wr && (int'(level_nx) > int'(thr_value)) |=> rx_full); // R3
endmodule

// File: tb/rx_byte_queue_test.sv
module rx_byte_queue_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, receiving = 1'b0, engine_idle = 1'b1, flush = 1'b0;
  logic       push_valid = 1'b0, pop_req = 1'b0, thr_wr = 1'b0;
  logic       clr_over = 1'b0, clr_under = 1'b0;
  logic [7:0] push_data = '0, thr_wdata = '0;
  logic [7:0] pop_data, thr_value;
  logic [4:0] level;
  logic       rx_full, rx_over, rx_under;

  int vectors = 0;
  int miscompares = 0;
  int exp_lvl = 0;
  logic [7:0] sb[$];

  always #(PERIOD/2) clk = ~clk;

  rx_byte_queue uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .receiving(receiving),
    .engine_idle(engine_idle), .flush(flush), .push_valid(push_valid),
    .push_data(push_data), .pop_req(pop_req), .pop_data(pop_data),
    .thr_wr(thr_wr), .thr_wdata(thr_wdata), .thr_value(thr_value),
    .level(level), .rx_full(rx_full), .rx_over(rx_over), .rx_under(rx_under),
    .clr_over(clr_over), .clr_under(clr_under)
  );

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // Driver: offers a byte and records it in the scoreboard when it fits.
  task automatic push_byte(logic [7:0] d);
    push_valid = 1'b1; push_data = d;
    if (exp_lvl < DEPTH) begin sb.push_back(d); exp_lvl++; end
    tick();
    push_valid = 1'b0;
  endtask

  // Monitor: reads one byte and compares it to the scoreboard head.
  task automatic pop_byte(string req);
    logic [7:0] e;
    pop_req = 1'b1;
    #1;
    if (receiving && sb.size() > 0) begin e = sb.pop_front(); exp_lvl--; end
    else e = 8'h00;
    chk(req, pop_data, e);
    tick();
    pop_req = 1'b0;
  endtask

  task automatic write_thr(logic [7:0] v);
    thr_wr = 1'b1; thr_wdata = v;
    tick();
    thr_wr = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(PERIOD * 3);
    // R12 reset state
    chk("R12 level", level, 0);
    chk("R12 thr", thr_value, 0);
    chk("R12 flags", {rx_full, rx_over, rx_under}, 0);
    @(negedge clk); rst_n = 1'b1;
    tick();
    enable = 1'b1; receiving = 1'b1; engine_idle = 1'b0;

    // R2 clamp
    write_thr(8'd200);
    chk("R2 clamp", thr_value, 15);
    write_thr(8'd3);
    chk("R2 plain", thr_value, 3);

    // R3 set after push exceeding threshold
    push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
    chk("R3 at threshold", rx_full, 0);
    push_byte(8'h44);
    chk("R1 level", level, 4);
    chk("R3 above threshold", rx_full, 1);

    // R4 clear after pop
    pop_byte("R1 first byte");
    chk("R1 level after pop", level, 3);
    chk("R4 cleared", rx_full, 0);

    // R5 threshold re-evaluation
    write_thr(8'd1);
    chk("R5 enabled set", rx_full, 1);
    enable = 1'b0;
    write_thr(8'd1);
    chk("R5 disabled clear", rx_full, 0);
    enable = 1'b1;

    // R10 simultaneous push and pop
    push_valid = 1'b1; push_data = 8'h55; pop_req = 1'b1;
    #1;
    chk("R10 head data", pop_data, sb[0]);
    void'(sb.pop_front()); sb.push_back(8'h55);
    tick();
    push_valid = 1'b0; pop_req = 1'b0;
    chk("R10 level held", level, 3);

    // R6 fill and overflow
    for (int i = 0; i < 13; i++) push_byte(8'h60 + 8'(i));
    chk("R1 full level", level, 16);
    push_byte(8'hEE);
    chk("R6 level kept", level, 16);
    chk("R6 over set", rx_over, 1);
    clr_over = 1'b1; tick(); clr_over = 1'b0;
    chk("R11 over cleared", rx_over, 0);

    // R8 reads outside the receive phase
    receiving = 1'b0;
    pop_byte("R8 busy read data");
    chk("R8 busy level", level, 16);
    chk("R8 busy under", rx_under, 1);
    clr_under = 1'b1; tick(); clr_under = 1'b0;
    chk("R11 under cleared", rx_under, 0);
    engine_idle = 1'b1;
    pop_byte("R8 idle read data");
    chk("R8 idle under", rx_under, 0);
    chk("R8 idle level", level, 16);
    engine_idle = 1'b0; receiving = 1'b1;

    // R1 drain in order
    for (int i = 0; i < DEPTH; i++) begin
      pop_byte("R1 drain order");
      chk("R1 drain level", level, exp_lvl);
    end
    chk("R4 drained", rx_full, 0);

    // R7 empty read
    pop_byte("R7 empty data");
    chk("R7 under set", rx_under, 1);

    // R9 flush
    push_byte(8'hA1); push_byte(8'hA2); push_byte(8'hA3);
    push_byte(8'hA4); push_byte(8'hA5);
    push_valid = 1'b1; push_data = 8'hB0;
    for (int i = 0; i < 12; i++) begin tick(); sb.push_back(8'hB0); exp_lvl++; end
    push_valid = 1'b0;
    chk("R6 setup full", level, 16);
    push_byte(8'hB1);
    flush = 1'b1; tick(); flush = 1'b0;
    sb.delete(); exp_lvl = 0;
    chk("R9 level", level, 0);
    chk("R9 flags", {rx_full, rx_over, rx_under}, 0);
    push_byte(8'hC7);
    pop_byte("R9 post-flush byte");
    chk("R9 final level", level, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule